// File: doc/BRIEF.md
# Video Frame Timing Generator

This block keeps the raster position for a tile-and-sprite video display processor. A column counter steps once per internal cycle across a scan line of 342 cycles. A row counter steps once per line. From these two counters the block decodes the active picture window and the vertical sync band. It also sets a frame interrupt flag as soon as the last active line has finished.

A select input chooses a 60 Hz frame of 262 lines or a 50 Hz frame of 312 lines. The choice is sampled only when a frame wraps, so a frame that has started always keeps its length.

The host reads a status strobe to acknowledge the interrupt. It can also read a countdown of the half-cycles left until the next interrupt point, which is the start of line 192. That countdown is scaled to a host clock of 228 cycles per line. It never shows zero: at the interrupt point it shows a whole frame.

Top module: `vdp_frame_timer`

## Requirements
- R1: `col` counts 0, 1, … up to LINE_CYCLES-1 (341) and then returns to 0. Each return to 0 moves `row` on by one.
- R2: `row` returns to 0 after the last line of the frame: line 261 when the frame mode is 60 Hz, and line 311 when it is 50 Hz. `pal_sel`=1 selects 50 Hz.
- R3: The frame mode takes the value of `pal_sel` only on the edge where `col` wraps from the last line. A change of `pal_sel` in the middle of a frame does not change that frame's length.
- R4: `active_video` is 1 exactly when `row` < 192 and HACT_FIRST ≤ `col` < HACT_FIRST+HACT_COUNT.
- R5: `vsync` is 1 exactly when `row` is in [start, start+VSYNC_LINES). The start is line 227 in 60 Hz mode and line 276 in 50 Hz mode.
- R6: An internal frame flag is set on the edge that ends column 341 of line 191. `irq` equals that flag ANDed with `irq_en`.
- R7: A clock edge with `status_rd`=1 clears the flag. If the flag is set on that same edge, setting wins.
- R8: `countdown` = (T + F − P) mod F. Here P = row·456 + ⌊col·456/342⌋, T = 192·456 and F = lines·456.
- R9: `countdown` is never 0. At P = T it equals F.
- R10: While `rst_n`=0, the following hold on each clock edge:
  - `col`, `row` and the flag are cleared.
  - The frame mode loads from `pal_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_sel | input | 1 | 1 = 50 Hz frame (312 lines), 0 = 60 Hz frame (262 lines) |
| irq_en | input | 1 | Interrupt enable gating `irq` |
| status_rd | input | 1 | Status read strobe; acknowledges the frame flag |
| col | output | 9 | Column within the line |
| row | output | 9 | Line within the frame |
| active_video | output | 1 | Inside the active picture window |
| vsync | output | 1 | Inside the vertical sync band |
| irq | output | 1 | Frame interrupt line |
| countdown | output | 18 | Half-cycles until the start of line 192 |

## Verification
The bench runs a shrunk raster: 12-cycle lines, 4 active lines, and frames of 7 or 9 lines. It compares every output on every cycle over dozens of whole frames.

The stimulus covers the following cases, each aimed at a different fault:
- Steady 60 Hz frames separate the wrap points and the region decoding.
- Changes of `pal_sel` in the middle of a frame show whether the mode is latched at the boundary or taken at once.
- A pseudo-random status strobe shows whether set-versus-clear priority and the enable gating are right.
- A strobe held high separates "set wins" from "clear wins".

The countdown is modelled as a modulo of the frame length, independently of the design's compare-and-subtract form. As a result, the zero-to-full-frame substitution at the interrupt point is checked once in every frame.

// File: rtl/vdp_timing_pkg.sv
// Package: shared types for the frame timing generator.
// Assumes nothing beyond SystemVerilog-2017 enums.
package vdp_timing_pkg;

    // Frame standard currently in force
    typedef enum logic {
        VMODE_60HZ = 1'b0,
        VMODE_50HZ = 1'b1
    } vmode_e;

endpackage

// File: rtl/vdp_raster_counter.sv
// Module: raster column/row counter.
// Steps the column every clock and the row at each column wrap.
// The frame standard is latched only at the frame wrap.
// Assumes LINE_CYCLES fits COL_W bits and PAL_LINES, NTSC_LINES fit ROW_W bits.
module vdp_raster_counter
    import vdp_timing_pkg::*;
#(
    parameter int LINE_CYCLES = 342,
    parameter int NTSC_LINES  = 262,
    parameter int PAL_LINES   = 312,
    parameter int COL_W       = $clog2(LINE_CYCLES),
    parameter int ROW_W       = $clog2(PAL_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pal_sel,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output vmode_e           mode,
    output logic             line_end,
    output logic             frame_end
);

    localparam logic [COL_W-1:0] COL_LAST  = COL_W'(LINE_CYCLES - 1);
    localparam logic [ROW_W-1:0] ROW_LAST6 = ROW_W'(NTSC_LINES - 1);
    localparam logic [ROW_W-1:0] ROW_LAST5 = ROW_W'(PAL_LINES - 1);

    logic [ROW_W-1:0] row_last;
    vmode_e           mode_next;

    // Decode the wrap points for the frame standard in force
    always_comb begin
        row_last  = (mode == VMODE_50HZ) ? ROW_LAST5 : ROW_LAST6;
        line_end  = (col == COL_LAST);
        frame_end = line_end && (row == row_last);
        mode_next = pal_sel ? VMODE_50HZ : VMODE_60HZ;
    end

    // Column counter: wraps at the end of each line
    always_ff @(posedge clk) begin
        if (!rst_n)        col <= '0;
        else if (line_end) col <= '0;
        else               col <= col + COL_W'(1);
    end

    // Row counter: steps per line, wraps at the end of the frame
    always_ff @(posedge clk) begin
        if (!rst_n)         row <= '0;
        else if (frame_end) row <= '0;
        else if (line_end)  row <= row + ROW_W'(1);
    end

    // Frame standard: loaded in reset and at each frame wrap only
    always_ff @(posedge clk) begin
        if (!rst_n)         mode <= mode_next;
        else if (frame_end) mode <= mode_next;
    end

    // R1
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (col == '0));

    // R1
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col <= COL_LAST);

    // R2
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_end) |=> (row == $past(row) + ROW_W'(1)));

    // R2
    row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (row == '0));

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(mode));

endmodule

// File: rtl/vdp_frame_irq.sv
// Module: frame interrupt flag.
// Set by a one-cycle event and cleared by the status read strobe. Setting wins.
// The output line is the flag gated by the enable.
// Assumes set_evt is a single-cycle pulse from the raster counter.
module vdp_frame_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic enable,
    output logic irq_line
);

    logic flag;

    // Pending flag: set has priority over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end

    // Drive the interrupt line only while enabled
    assign irq_line = flag & enable;

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R6
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set_evt) |=> !flag);

    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag);

endmodule

// File: rtl/vdp_irq_countdown.sv
// Module: half-cycles remaining until the interrupt point.
// Converts the raster position into host half-cycles at HC_PER_LINE per line.
// Returns the distance forward to the start of line ACTIVE_LINES.
// Returns a whole frame instead of zero.
// Assumes CD_W holds (ACTIVE_LINES + PAL_LINES) * HC_PER_LINE.
module vdp_irq_countdown
    import vdp_timing_pkg::*;
#(
    parameter int LINE_CYCLES  = 342,
    parameter int HC_PER_LINE  = 456,
    parameter int ACTIVE_LINES = 192,
    parameter int NTSC_LINES   = 262,
    parameter int PAL_LINES    = 312,
    parameter int COL_W        = 9,
    parameter int ROW_W        = 9,
    parameter int CD_W         = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  vmode_e           mode,
    output logic [CD_W-1:0]  countdown
);

    localparam logic [CD_W-1:0] TARGET_HC = CD_W'(ACTIVE_LINES * HC_PER_LINE);
    localparam logic [CD_W-1:0] FRAME6_HC = CD_W'(NTSC_LINES * HC_PER_LINE);
    localparam logic [CD_W-1:0] FRAME5_HC = CD_W'(PAL_LINES * HC_PER_LINE);

    logic [CD_W-1:0] line_hc;
    logic [CD_W-1:0] frac_hc;
    logic [CD_W-1:0] pos_hc;
    logic [CD_W-1:0] frame_hc;

    // Position in host half-cycles, then the forward distance to the target
    always_comb begin
        line_hc  = CD_W'(row) * CD_W'(HC_PER_LINE);
        frac_hc  = CD_W'((32'(col) * 32'(HC_PER_LINE)) / 32'(LINE_CYCLES));
        pos_hc   = line_hc + frac_hc;
        frame_hc = (mode == VMODE_50HZ) ? FRAME5_HC : FRAME6_HC;
        if (pos_hc < TARGET_HC) countdown = TARGET_HC - pos_hc;
        else                    countdown = TARGET_HC + frame_hc - pos_hc;
    end

    // R9
    cd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        countdown != '0);

    // R8
    cd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        countdown <= frame_hc);

endmodule

// File: rtl/vdp_frame_timer.sv
// Module: frame timing generator top.
// Holds the raster counters and decodes the active window and the vsync band.
// Raises the frame interrupt after the last active line and presents the countdown.
// Assumes HACT_FIRST + HACT_COUNT <= LINE_CYCLES and both sync bands lie inside their frames.
module vdp_frame_timer
    import vdp_timing_pkg::*;
#(
    parameter int LINE_CYCLES  = 342,
    parameter int HC_PER_LINE  = 456,
    parameter int ACTIVE_LINES = 192,
    parameter int NTSC_LINES   = 262,
    parameter int PAL_LINES    = 312,
    parameter int NTSC_VS_LINE = 227,
    parameter int PAL_VS_LINE  = 276,
    parameter int VSYNC_LINES  = 3,
    parameter int HACT_FIRST   = 60,
    parameter int HACT_COUNT   = 256,
    parameter int COL_W        = $clog2(LINE_CYCLES),
    parameter int ROW_W        = $clog2(PAL_LINES),
    parameter int CD_W         = $clog2((ACTIVE_LINES + PAL_LINES) * HC_PER_LINE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pal_sel,
    input  logic             irq_en,
    input  logic             status_rd,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic             active_video,
    output logic             vsync,
    output logic             irq,
    output logic [CD_W-1:0]  countdown
);

    localparam logic [COL_W-1:0] HACT_LO  = COL_W'(HACT_FIRST);
    localparam logic [COL_W-1:0] HACT_HI  = COL_W'(HACT_FIRST + HACT_COUNT);
    localparam logic [ROW_W-1:0] ACT_ROWS = ROW_W'(ACTIVE_LINES);
    localparam logic [ROW_W-1:0] IRQ_ROW  = ROW_W'(ACTIVE_LINES - 1);
    localparam logic [ROW_W-1:0] VS6_LO   = ROW_W'(NTSC_VS_LINE);
    localparam logic [ROW_W-1:0] VS6_HI   = ROW_W'(NTSC_VS_LINE + VSYNC_LINES);
    localparam logic [ROW_W-1:0] VS5_LO   = ROW_W'(PAL_VS_LINE);
    localparam logic [ROW_W-1:0] VS5_HI   = ROW_W'(PAL_VS_LINE + VSYNC_LINES);

    vmode_e mode;
    logic   line_end;
    logic   frame_end;
    logic   irq_set;
    logic   [ROW_W-1:0] vs_lo;
    logic   [ROW_W-1:0] vs_hi;

    vdp_raster_counter #(
        .LINE_CYCLES (LINE_CYCLES),
        .NTSC_LINES  (NTSC_LINES),
        .PAL_LINES   (PAL_LINES),
        .COL_W       (COL_W),
        .ROW_W       (ROW_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pal_sel   (pal_sel),
        .col       (col),
        .row       (row),
        .mode      (mode),
        .line_end  (line_end),
        .frame_end (frame_end)
    );

    // The interrupt point is the edge that ends the last active line
    assign irq_set = line_end && (row == IRQ_ROW);

    vdp_frame_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (irq_set),
        .clr_evt  (status_rd),
        .enable   (irq_en),
        .irq_line (irq)
    );

    vdp_irq_countdown #(
        .LINE_CYCLES  (LINE_CYCLES),
        .HC_PER_LINE  (HC_PER_LINE),
        .ACTIVE_LINES (ACTIVE_LINES),
        .NTSC_LINES   (NTSC_LINES),
        .PAL_LINES    (PAL_LINES),
        .COL_W        (COL_W),
        .ROW_W        (ROW_W),
        .CD_W         (CD_W)
    ) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .col       (col),
        .row       (row),
        .mode      (mode),
        .countdown (countdown)
    );

    // Region decode: active picture window and vertical sync band
    always_comb begin
        vs_lo        = (mode == VMODE_50HZ) ? VS5_LO : VS6_LO;
        vs_hi        = (mode == VMODE_50HZ) ? VS5_HI : VS6_HI;
        active_video = (row < ACT_ROWS) && (col >= HACT_LO) && (col < HACT_HI);
        vsync        = (row >= vs_lo) && (row < vs_hi);
    end

    // R4
    active_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_video |-> (row < ACT_ROWS));

    // R5
    vsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> !active_video);

endmodule

// File: tb/tb_vdp_frame_timer.sv
// Bench: cycle-by-cycle comparison against an arithmetic model on a shrunk raster.
module tb_vdp_frame_timer;

    localparam int LC  = 12;
    localparam int HCL = 16;
    localparam int AL  = 4;
    localparam int NL  = 7;
    localparam int PL  = 9;
    localparam int NVS = 5;
    localparam int PVS = 6;
    localparam int VSL = 2;
    localparam int HF  = 2;
    localparam int HC  = 8;
    localparam int CW  = $clog2(LC);
    localparam int RW  = $clog2(PL);
    localparam int DW  = $clog2((AL + PL) * HCL + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pal_sel;
    logic          irq_en;
    logic          status_rd;
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic          active_video;
    logic          vsync;
    logic          irq;
    logic [DW-1:0] countdown;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;
    int  m_col, m_row, m_pal, m_flag, m_en;
    logic [7:0] lf = 8'hA5;

    vdp_frame_timer #(
        .LINE_CYCLES (LC), .HC_PER_LINE (HCL), .ACTIVE_LINES (AL),
        .NTSC_LINES (NL), .PAL_LINES (PL), .NTSC_VS_LINE (NVS),
        .PAL_VS_LINE (PVS), .VSYNC_LINES (VSL), .HACT_FIRST (HF),
        .HACT_COUNT (HC)
    ) dut (
        .clk (clk), .rst_n (rst_n), .pal_sel (pal_sel), .irq_en (irq_en),
        .status_rd (status_rd), .col (col), .row (row),
        .active_video (active_video), .vsync (vsync), .irq (irq),
        .countdown (countdown)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_cd();
        int pos, frm, tgt, rem;
        pos = m_row * HCL + (m_col * HCL) / LC;
        frm = (m_pal ? PL : NL) * HCL;
        tgt = AL * HCL;
        rem = (tgt + frm - pos) % frm;
        return (rem == 0) ? frm : rem;
    endfunction

    task automatic check_all();
        int vs0;
        vs0 = m_pal ? PVS : NVS;
        chk("R1 col", int'(col), m_col);
        chk("R2 R3 row", int'(row), m_row);
        chk("R4 active_video", int'(active_video),
            int'(m_row < AL && m_col >= HF && m_col < HF + HC));
        chk("R5 vsync", int'(vsync), int'(m_row >= vs0 && m_row < vs0 + VSL));
        chk("R6 R7 irq", int'(irq), m_flag & m_en);
        if (exp_cd() == (m_pal ? PL : NL) * HCL)
            chk("R9 countdown full frame", int'(countdown), exp_cd());
        else
            chk("R8 countdown", int'(countdown), exp_cd());
    endtask

    // One clock: drive inputs, advance the model on the edge, check at the falling edge
    task automatic cyc(input logic p, input logic e, input logic r);
        int last;
        pal_sel = p; irq_en = e; status_rd = r;
        @(posedge clk);
        last = m_pal ? PL - 1 : NL - 1;
        if (m_col == LC - 1 && m_row == AL - 1) m_flag = 1;
        else if (r)                             m_flag = 0;
        if (m_col == LC - 1) begin
            m_col = 0;
            if (m_row == last) begin m_row = 0; m_pal = int'(p); end
            else m_row++;
        end else m_col++;
        m_en = int'(e);
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset(input logic p);
        rst_n = 1'b0; pal_sel = p; irq_en = 1'b1; status_rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_col = 0; m_row = 0; m_pal = int'(p); m_flag = 0; m_en = 1;
        chk("R10 reset col", int'(col), 0);
        chk("R10 reset row", int'(row), 0);
        chk("R10 reset irq", int'(irq), 0);
        chk("R10 reset countdown", int'(countdown), AL * HCL);
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] lfsr(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    initial begin
        do_reset(1'b0);
        // Steady 60 Hz frames, random acknowledges
        for (int i = 0; i < 10 * NL * LC; i++) begin
            lf = lfsr(lf);
            cyc(1'b0, 1'b1, lf[0] & lf[3]);
        end
        // Switch to 50 Hz in mid-frame (R3), random enable and strobe
        for (int i = 0; i < 3 * LC; i++) cyc(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10 * PL * LC; i++) begin
            lf = lfsr(lf);
            cyc(1'b1, lf[2], lf[1] & lf[6]);
        end
        // Strobe held high: set must win on the interrupt edge (R7)
        for (int i = 0; i < 3 * PL * LC; i++) cyc(1'b1, 1'b1, 1'b1);
        // Enable off then on with the flag pending (R6)
        for (int i = 0; i < 2 * PL * LC; i++) cyc(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 2 * PL * LC; i++) cyc(1'b1, 1'b1, 1'b0);
        // Back to 60 Hz in mid-frame
        for (int i = 0; i < 6 * NL * LC; i++) begin
            lf = lfsr(lf);
            cyc(1'b0, 1'b1, lf[4]);
        end
        // Reset with the 50 Hz select held (R10)
        do_reset(1'b1);
        for (int i = 0; i < 3 * PL * LC; i++) cyc(1'b1, 1'b1, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule